// File: doc/BRIEF.md
# Two-Level Cascaded Interrupt Aggregator

This block gathers interrupt requests from three byte-wide groups of sources and from two timers, and presents them to a processor as four interrupt lines. Two groups, level 0 and level 1, are local sources. Each local group has a status view and a mask. The masked OR of each local group drives one processor line. The third group holds eight shared sources. Two independent route masks pick which of these shared sources feed level 0 and which feed level 1. The OR of each routed set appears as one designated bit of the receiving local group's status. It is then masked and reported like any local source.

The two timer requests are edge-triggered. Each edge sets a sticky flag, and each flag drives its own processor line. Software clears a flag by writing a 1 to the matching bit of a write-only clear register.

All control goes through a byte-wide register port: a 3-bit offset, a write strobe and write data. Read data is a combinational function of the offset. There is no data stream at the block's edge, so every pin is a plain level or strobe. A write takes effect on the clock edge where `reg_wr` is high.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: After a synchronous reset, all four masks read 0x00, both timer flags are clear, and all four interrupt outputs are 0.
- R2: Offset 0 reads level-0 status and offset 2 reads level-1 status. Each shows the raw source levels, regardless of mask. A source level sampled at clock edge n is visible from edge n+1, after a two-flop synchroniser.
- R3: Offsets 1, 3, 5 and 6 hold the level-0 mask, the level-1 mask, route mask 0 and route mask 1. Each is read/write, with bit n controlling source n. A write is readable from the edge that performs it.
- R4: `irq_l0` is registered. After edge n it equals the OR of (level-0 status AND level-0 mask) as it stood just before edge n.
- R5: `irq_l1` follows the same rule for the level-1 status and mask.
- R6: Offset 4 reads the synchronised shared-source status, regardless of either route mask.
- R7: Level-0 status bit `CASC0_BIT` (default 2) is the OR of its local input and of (shared status AND route mask 0). Level-1 status bit `CASC1_BIT` (default 3) is formed the same way from route mask 1.
- R8: A rising edge on `tmr_req[k]` sets timer flag k, two edges after the edge that samples the high level. `irq_tmr[k]` is the flag. The flag stays set while the request is held high or falls, until it is cleared.
- R9: Writing offset 7 clears timer flag 0 when bit 0 of the data is 1, and timer flag 1 when bit 1 is 1; writing 0x03 clears both. A 0 bit leaves its flag unchanged. If a new rising edge is detected in the same cycle as the clear, the flag stays set.
- R10: Offset 7 reads 0x00. Writes to offsets 0, 2 and 4 change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_l0 | input | 8 | Level-0 local source levels (asynchronous) |
| src_l1 | input | 8 | Level-1 local source levels (asynchronous) |
| src_map | input | 8 | Shared routable source levels (asynchronous) |
| tmr_req | input | 2 | Timer interrupt requests, edge-detected |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| irq_l0 | output | 1 | Processor line 0: level-0 aggregate |
| irq_l1 | output | 1 | Processor line 1: level-1 aggregate |
| irq_tmr | output | 2 | Processor lines 2 and 3: timer flags |

## Verification
The hardest case to reach from the ports is a timer clear that lands on exactly the cycle in which a new rising edge is detected. The edge sits behind three registers, so the bench raises the request and then issues the clear write two falling edges later, which makes the write coincide with the edge detection. A second hard case is a shared source routed to both levels at once. Route masks are written with overlapping bits while the local masks cover the cascade bits, so both lines rise from one shared input. A behavioural model tracks every cycle through delay stages and compares the outputs and read data on every clock.

// File: rtl/cic_pkg.sv
package cic_pkg;
  localparam int GRP_W  = 8;
  localparam int ADDR_W = 3;
  localparam int N_TMR  = 2;

  typedef enum logic [ADDR_W-1:0] {
    OFS_L0_STAT = 3'd0,
    OFS_L0_MASK = 3'd1,
    OFS_L1_STAT = 3'd2,
    OFS_L1_MASK = 3'd3,
    OFS_MP_STAT = 3'd4,
    OFS_MP_RT0  = 3'd5,
    OFS_MP_RT1  = 3'd6,
    OFS_TCLR    = 3'd7
  } cic_ofs_e;

  typedef logic [GRP_W-1:0] grp_t;
endpackage

// File: rtl/cic_sync.sv
module cic_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/cic_timer_latch.sv
module cic_timer_latch #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flag
);
  logic [N-1:0] req_s;
  logic [N-1:0] req_prev;
  logic [N-1:0] rise;

  cic_sync #(.W(N)) u_sync (.clk(clk), .rst(rst), .d(req), .q(req_s));

  always_ff @(posedge clk) begin
    if (rst) req_prev <= '0;
    else     req_prev <= req_s;
  end

  assign rise = req_s & ~req_prev;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)         flag[i] <= 1'b0;
      else if (rise[i]) flag[i] <= 1'b1;
      else if (clr[i])  flag[i] <= 1'b0;
    end

    assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
      (flag[i] && !clr[i]) |=> flag[i]);

    assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
      (clr[i] && !rise[i]) |=> !flag[i]);

    assert_edge_wins_R9: assert property (@(posedge clk) disable iff (rst)
      rise[i] |=> flag[i]);
  end
endmodule

// File: rtl/cic_regs.sv
module cic_regs
  import cic_pkg::*;
#(
  parameter int N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [GRP_W-1:0]  wdata,
  input  grp_t              stat_l0,
  input  grp_t              stat_l1,
  input  grp_t              stat_mp,
  output grp_t              mask_l0,
  output grp_t              mask_l1,
  output grp_t              route0,
  output grp_t              route1,
  output logic [N-1:0]      tclr,
  output logic [GRP_W-1:0]  rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_l0 <= '0;
      mask_l1 <= '0;
      route0  <= '0;
      route1  <= '0;
    end else if (wr) begin
      case (cic_ofs_e'(addr))
        OFS_L0_MASK: mask_l0 <= wdata;
        OFS_L1_MASK: mask_l1 <= wdata;
        OFS_MP_RT0:  route0  <= wdata;
        OFS_MP_RT1:  route1  <= wdata;
        default: ;
      endcase
    end
  end

  assign tclr = (wr && cic_ofs_e'(addr) == OFS_TCLR) ? wdata[N-1:0] : '0;

  always_comb begin
    case (cic_ofs_e'(addr))
      OFS_L0_STAT: rdata = stat_l0;
      OFS_L0_MASK: rdata = mask_l0;
      OFS_L1_STAT: rdata = stat_l1;
      OFS_L1_MASK: rdata = mask_l1;
      OFS_MP_STAT: rdata = stat_mp;
      OFS_MP_RT0:  rdata = route0;
      OFS_MP_RT1:  rdata = route1;
      default:     rdata = '0;
    endcase
  end

  assert_mask_write_R3: assert property (@(posedge clk) disable iff (rst)
    (wr && cic_ofs_e'(addr) == OFS_L0_MASK) |=> (mask_l0 == $past(wdata)));

  assert_ro_write_R10: assert property (@(posedge clk) disable iff (rst)
    (wr && (cic_ofs_e'(addr) == OFS_L0_STAT || cic_ofs_e'(addr) == OFS_MP_STAT))
      |=> ($stable(mask_l0) && $stable(mask_l1) && $stable(route0) && $stable(route1)));

  always_comb begin
    if (!rst && cic_ofs_e'(addr) == OFS_TCLR)
      assert_wo_reads_zero_R10: assert (rdata == '0);
  end
endmodule

// File: rtl/cascade_irq_ctrl.sv
module cascade_irq_ctrl
  import cic_pkg::*;
#(
  parameter int CASC0_BIT = 2,
  parameter int CASC1_BIT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [GRP_W-1:0]  src_l0,
  input  logic [GRP_W-1:0]  src_l1,
  input  logic [GRP_W-1:0]  src_map,
  input  logic [N_TMR-1:0]  tmr_req,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [GRP_W-1:0]  reg_wdata,
  output logic [GRP_W-1:0]  reg_rdata,
  output logic              irq_l0,
  output logic              irq_l1,
  output logic [N_TMR-1:0]  irq_tmr
);
  grp_t l0_s, l1_s, mp_s;
  grp_t stat_l0, stat_l1;
  grp_t mask_l0, mask_l1, route0, route1;
  logic [N_TMR-1:0] tclr;
  logic casc0, casc1;

  cic_sync #(.W(GRP_W)) u_sync_l0 (.clk(clk), .rst(rst), .d(src_l0),  .q(l0_s));
  cic_sync #(.W(GRP_W)) u_sync_l1 (.clk(clk), .rst(rst), .d(src_l1),  .q(l1_s));
  cic_sync #(.W(GRP_W)) u_sync_mp (.clk(clk), .rst(rst), .d(src_map), .q(mp_s));

  assign casc0 = |(mp_s & route0);
  assign casc1 = |(mp_s & route1);

  always_comb begin
    stat_l0 = l0_s;
    stat_l1 = l1_s;
    stat_l0[CASC0_BIT] = l0_s[CASC0_BIT] | casc0;
    stat_l1[CASC1_BIT] = l1_s[CASC1_BIT] | casc1;
  end

  cic_regs #(.N(N_TMR)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .stat_l0(stat_l0), .stat_l1(stat_l1), .stat_mp(mp_s),
    .mask_l0(mask_l0), .mask_l1(mask_l1), .route0(route0), .route1(route1),
    .tclr(tclr), .rdata(reg_rdata)
  );

  cic_timer_latch #(.N(N_TMR)) u_tmr (
    .clk(clk), .rst(rst), .req(tmr_req), .clr(tclr), .flag(irq_tmr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_l0 <= 1'b0;
      irq_l1 <= 1'b0;
    end else begin
      irq_l0 <= |(stat_l0 & mask_l0);
      irq_l1 <= |(stat_l1 & mask_l1);
    end
  end

  assert_l0_line_R4: assert property (@(posedge clk) disable iff (rst)
    (mask_l0 == '0) |=> !irq_l0);

  assert_l1_line_R5: assert property (@(posedge clk) disable iff (rst)
    (mask_l1 == '0) |=> !irq_l1);

  assert_cascade_R7: assert property (@(posedge clk) disable iff (rst)
    (casc0 && mask_l0[CASC0_BIT]) |=> irq_l0);
endmodule

// File: tb/cascade_irq_ctrl_test.sv
module cascade_irq_ctrl_test;
  localparam int C0 = 2;
  localparam int C1 = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] src_l0 = '0, src_l1 = '0, src_map = '0;
  logic [1:0] tmr_req = '0;
  logic [2:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq_l0, irq_l1;
  logic [1:0] irq_tmr;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit active = 1'b0;

  always #10 clk = ~clk;

  cascade_irq_ctrl #(.CASC0_BIT(C0), .CASC1_BIT(C1)) uut (
    .clk(clk), .rst(rst), .src_l0(src_l0), .src_l1(src_l1), .src_map(src_map),
    .tmr_req(tmr_req), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_l0(irq_l0), .irq_l1(irq_l1), .irq_tmr(irq_tmr)
  );

  // behavioural model: input history queues give the synchroniser delay
  logic [7:0] q_l0[$], q_l1[$], q_mp[$];
  logic [1:0] q_t[$];
  logic [7:0] m_mask0 = 0, m_mask1 = 0, m_rt0 = 0, m_rt1 = 0;
  logic       m_irq0 = 0, m_irq1 = 0;
  logic [1:0] m_flag = 0;

  function automatic logic [7:0] seen(ref logic [7:0] q[$]);
    return (q.size() >= 2) ? q[q.size()-2] : 8'h00;
  endfunction

  function automatic logic [7:0] m_stat0();
    logic [7:0] s;
    s = seen(q_l0);
    if (|(seen(q_mp) & m_rt0)) s[C0] = 1'b1;
    return s;
  endfunction

  function automatic logic [7:0] m_stat1();
    logic [7:0] s;
    s = seen(q_l1);
    if (|(seen(q_mp) & m_rt1)) s[C1] = 1'b1;
    return s;
  endfunction

  function automatic logic [1:0] tseen(int back);
    return (q_t.size() > back) ? q_t[q_t.size()-1-back] : 2'b00;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      q_l0.delete(); q_l1.delete(); q_mp.delete(); q_t.delete();
      m_mask0 = 0; m_mask1 = 0; m_rt0 = 0; m_rt1 = 0;
      m_irq0 = 0; m_irq1 = 0; m_flag = 0;
    end else begin
      logic [1:0] rise, clr;
      m_irq0 = |(m_stat0() & m_mask0);
      m_irq1 = |(m_stat1() & m_mask1);
      // edge seen now: synchronised level two edges back, not three back
      rise = tseen(1) & ~tseen(2);
      clr  = (reg_wr && reg_addr == 3'd7) ? reg_wdata[1:0] : 2'b00;
      m_flag = (m_flag & ~clr) | rise;
      if (reg_wr) begin
        case (reg_addr)
          3'd1: m_mask0 = reg_wdata;
          3'd3: m_mask1 = reg_wdata;
          3'd5: m_rt0   = reg_wdata;
          3'd6: m_rt1   = reg_wdata;
          default: ;
        endcase
      end
      q_l0.push_back(src_l0); q_l1.push_back(src_l1);
      q_mp.push_back(src_map); q_t.push_back(tmr_req);
      if (q_l0.size() > 4) begin
        void'(q_l0.pop_front()); void'(q_l1.pop_front()); void'(q_mp.pop_front());
      end
      if (q_t.size() > 4) void'(q_t.pop_front());
    end
  end

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h cycle=%0d", req, act, exp, cycles);
    end
  endtask

  function automatic logic [7:0] m_rdata(logic [2:0] a);
    case (a)
      3'd0: return m_stat0();
      3'd1: return m_mask0;
      3'd2: return m_stat1();
      3'd3: return m_mask1;
      3'd4: return seen(q_mp);
      3'd5: return m_rt0;
      3'd6: return m_rt1;
      default: return 8'h00;
    endcase
  endfunction

  always @(negedge clk) begin
    cycles++;
    if (active) begin
      check("R4 R7 irq_l0", {7'd0, irq_l0}, {7'd0, m_irq0});
      check("R5 R7 irq_l1", {7'd0, irq_l1}, {7'd0, m_irq1});
      check("R8 R9 irq_tmr", {6'd0, irq_tmr}, {6'd0, m_flag});
      case (reg_addr)
        3'd0, 3'd2: check("R2 R7 status read", reg_rdata, m_rdata(reg_addr));
        3'd4:       check("R6 shared status read", reg_rdata, m_rdata(reg_addr));
        3'd7:       check("R10 clear offset read", reg_rdata, m_rdata(reg_addr));
        default:    check("R3 mask read", reg_rdata, m_rdata(reg_addr));
      endcase
    end
  end

  task automatic wr(logic [2:0] a, logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      reg_addr = 3'(i);
      @(negedge clk);
    end
  endtask

  initial begin
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state visible at the ports
    for (int a = 1; a < 8; a += 2) begin
      reg_addr = 3'(a);
      #1 check("R1 reset mask", reg_rdata, 8'h00);
    end
    reg_addr = 3'd6;
    #1 check("R1 reset route", reg_rdata, 8'h00);
    check("R1 reset lines", {4'd0, irq_l0, irq_l1, irq_tmr}, 8'h00);
    active = 1'b1;
    @(negedge clk);
    // R2: raw status with masks at zero
    src_l0 = 8'hA5; src_l1 = 8'h3C; src_map = 8'h81;
    idle(8);
    // R3 R4 R5 masks
    wr(3'd1, 8'h01); idle(3);
    wr(3'd3, 8'h40); idle(3);
    wr(3'd1, 8'h00); wr(3'd3, 8'h00); idle(3);
    // R10 writes to read-only offsets
    wr(3'd0, 8'hFF); wr(3'd2, 8'hFF); wr(3'd4, 8'hFF); idle(8);
    // R7 cascade into both levels from one shared source
    src_l0 = 8'h00; src_l1 = 8'h00; src_map = 8'h00;
    wr(3'd1, 8'h04); wr(3'd3, 8'h08);
    wr(3'd5, 8'h10); wr(3'd6, 8'h30); idle(4);
    src_map = 8'h10; idle(6);
    src_map = 8'h20; idle(6);
    wr(3'd5, 8'h00); idle(4);
    // R8 timer edges, held level, clears
    tmr_req = 2'b01; idle(6);
    tmr_req = 2'b11; idle(6);
    wr(3'd7, 8'h00); idle(2);
    wr(3'd7, 8'h01); idle(3);
    wr(3'd7, 8'h03); idle(3);
    tmr_req = 2'b00; idle(4);
    // R9 new edge in the same cycle as the clear
    tmr_req = 2'b10; idle(6);
    tmr_req = 2'b00; idle(4);
    tmr_req = 2'b10;
    @(negedge clk); @(negedge clk);
    wr(3'd7, 8'h02);
    idle(4);
    // mixed traffic
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      src_l0 = lfsr[7:0]; src_l1 = lfsr[15:8];
      if (lfsr[2]) src_map = lfsr[11:4];
      if (lfsr[5:3] == 3'd0) tmr_req = lfsr[9:8];
      reg_addr = lfsr[14:12];
      reg_wdata = lfsr[10:3];
      reg_wr = (lfsr[1:0] == 2'b00);
      @(negedge clk);
      reg_wr = 1'b0;
    end
    idle(8);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule